// File: doc/BRIEF.md
# Two-Wire Serial Byte-Memory Slave

This block is a bus slave for the two-wire serial protocol that holds 2048 bytes in on-chip storage. It oversamples the clock and data lines with the system clock and finds start and stop conditions in the sampled stream. It then takes bytes in and acknowledges them. A master can write one byte or a run of bytes within one 16-byte page. A master can read from the current position, from an address it sets first, or as a long sequential run.

Written bytes collect in a page buffer and reach the array only after a stop condition. The transfer takes a fixed number of system clocks, set by a parameter. While the transfer runs, the slave ignores its own address, so a master can poll until the write has finished. A write-protect input, sampled at the stop condition, cancels the transfer entirely. The data line is open-drain: the block only produces an enable that pulls the line low.

Top module: `serial_eeprom_slave`

## Requirements
- R1: A device byte whose upper four bits are 1010 (bit 0 = 1 for read, 0 for write) is acknowledged by pulling the data line low during the ninth clock; any other upper nibble is left unacknowledged and the rest of the transaction is ignored.
- R2: A write transaction made of the device byte (bits 3:1 = address bits 10:8), an address byte (address bits 7:0) and one data byte stores that byte at the 11-bit address; every byte of the transaction is acknowledged.
- R3: Successive data bytes of one write go to successive offsets in the low 4 address bits, wrapping from offset 15 to offset 0 of the same 16-byte page; a full page of 16 bytes is accepted.
- R4: The buffered bytes reach the array only after a stop condition, through an internal cycle of exactly WR_CYCLES system clocks; during that cycle every device byte is left unacknowledged and the data line is never pulled.
- R5: When the write-protect input is high at the stop condition, no internal cycle starts, the array keeps its old contents, and the next device byte is acknowledged at once.
- R6: A random read (write device byte, address byte, repeated start, read device byte) returns the byte stored at the address given.
- R7: A sequential read moves through the full 11-bit address for each byte the master acknowledges, rolling over from 0x7FF to 0x000.
- R8: A read that the master ends with a non-acknowledge and a stop leaves the position one past the last byte sent; a later read without an address byte starts there, and the address bits of a read device byte are ignored.
- R9: The pull-down enable changes only while the sampled clock is low, except that start and stop conditions release it; it is low after reset and after every stop.
- R10: A partial page write changes only the offsets it received; the other bytes of that page keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus lines |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus (wired value) |
| wp_i | input | 1 | Write protect; high blocks every array update |
| sda_pull_o | output | 1 | When high, the data line is pulled low; never drives it high |

## Verification
The end of the internal write cycle and the decision on an incoming device byte can fall in the same clock: the cycle counter expires while the eighth bit of a polling byte is being sampled. The bench provokes this by polling with back-to-back device bytes right after each write and judges it by the first acknowledged poll: it must be followed by a read that returns the newly written data, never the old value. The checker confirms separately that the busy window always lasts exactly the configured number of clocks and starts only from a stop condition with protection low.

// File: rtl/seeps_pkg.sv
package seeps_pkg;

   typedef enum logic [2:0] {
      MD_IDLE,
      MD_DEV,
      MD_ADDR,
      MD_WDATA,
      MD_RDATA,
      MD_SKIP
   } mode_e;

   localparam logic [3:0] DEV_PREFIX = 4'b1010;

endpackage

// File: rtl/seeps_line_sync.sv
module seeps_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_evt,
   output logic stop_evt
);

   logic [1:0] raw;
   logic [1:0] synced;
   logic       scl_q;
   logic       sda_q;

   assign raw = {scl_i, sda_i};

   for (genvar g = 0; g < 2; g++) begin : g_line
      logic [STAGES-1:0] chain;
      if (STAGES > 1) begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], raw[g]};
         end
      end else begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= raw[g];
         end
      end
      assign synced[g] = chain[STAGES-1];
   end

   assign scl_s = synced[1];
   assign sda_s = synced[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/seeps_array.sv
module seeps_array #(
   parameter int ADDR_W    = 11,
   parameter int PAGE_W    = 4,
   parameter int WR_CYCLES = 250000
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        rd_addr,
   output logic [7:0]               rd_data,
   input  logic                     buf_we,
   input  logic [PAGE_W-1:0]        buf_off,
   input  logic [7:0]               buf_din,
   input  logic                     buf_clr,
   input  logic                     commit,
   input  logic [ADDR_W-PAGE_W-1:0] commit_page,
   output logic                     busy
);

   localparam int DEPTH  = 1 << ADDR_W;
   localparam int PBYTES = 1 << PAGE_W;
   localparam int TW     = $clog2(WR_CYCLES + 1);

   logic [7:0]               mem   [DEPTH];
   logic [7:0]               pbuf  [PBYTES];
   logic [PBYTES-1:0]        pvalid;
   logic [ADDR_W-PAGE_W-1:0] page;
   logic [TW-1:0]            timer;
   logic                     done;

   assign rd_data = mem[rd_addr];
   assign done    = busy && (timer == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         timer  <= '0;
         page   <= '0;
         pvalid <= '0;
      end else if (busy) begin
         if (done) begin
            busy   <= 1'b0;
            pvalid <= '0;
         end else begin
            timer <= timer - 1'b1;
         end
      end else if (commit && (|pvalid)) begin
         busy  <= 1'b1;
         timer <= TW'(WR_CYCLES - 1);
         page  <= commit_page;
      end else if (buf_clr || commit) begin
         pvalid <= '0;
      end else if (buf_we) begin
         pvalid[buf_off] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (buf_we && !busy) pbuf[buf_off] <= buf_din;
      if (done) begin
         for (int i = 0; i < PBYTES; i++) begin
            if (pvalid[i]) mem[{page, PAGE_W'(i)}] <= pbuf[i];
         end
      end
   end

endmodule

// File: rtl/seeps_proto.sv
module seeps_proto
   import seeps_pkg::*;
#(
   parameter int ADDR_W = 11,
   parameter int PAGE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_evt,
   input  logic              stop_evt,
   input  logic              busy,
   input  logic [7:0]        rd_data,
   output logic [ADDR_W-1:0] addr,
   output logic              buf_we,
   output logic [PAGE_W-1:0] buf_off,
   output logic [7:0]        buf_din,
   output logic              sda_pull
);

   localparam int BW = ADDR_W - 8;

   mode_e         mode;
   mode_e         nxt_mode;
   logic [3:0]    bitcnt;
   logic [6:0]    shreg;
   logic [7:0]    rx_byte;
   logic          ack_go;
   logic [BW-1:0] blk;
   logic [7:0]    txbyte;
   logic          mack;
   logic [2:0]    bidx;

   assign rx_byte = {shreg, sda_s};
   assign bidx    = 3'(4'd7 - bitcnt);
   assign buf_we  = scl_rise && (bitcnt == 4'd7) && (mode == MD_WDATA);
   assign buf_off = addr[PAGE_W-1:0];
   assign buf_din = rx_byte;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode     <= MD_IDLE;
         nxt_mode <= MD_IDLE;
         bitcnt   <= '0;
         shreg    <= '0;
         ack_go   <= 1'b0;
         blk      <= '0;
         addr     <= '0;
         txbyte   <= '0;
         mack     <= 1'b0;
         sda_pull <= 1'b0;
      end else if (start_evt) begin
         mode     <= MD_DEV;
         bitcnt   <= '0;
         sda_pull <= 1'b0;
      end else if (stop_evt) begin
         mode     <= MD_IDLE;
         bitcnt   <= '0;
         sda_pull <= 1'b0;
      end else if (mode != MD_IDLE && mode != MD_SKIP) begin
         if (scl_rise) begin
            if (bitcnt != 4'd9) bitcnt <= bitcnt + 1'b1;
            if (bitcnt < 4'd8) shreg <= {shreg[5:0], sda_s};
            if (bitcnt == 4'd8 && mode == MD_RDATA) mack <= !sda_s;
            if (bitcnt == 4'd7) begin
               case (mode)
                  MD_DEV: begin
                     if (rx_byte[7:4] == DEV_PREFIX && !busy) begin
                        ack_go   <= 1'b1;
                        nxt_mode <= rx_byte[0] ? MD_RDATA : MD_ADDR;
                        if (!rx_byte[0]) blk <= rx_byte[BW:1];
                     end else begin
                        ack_go   <= 1'b0;
                        nxt_mode <= MD_SKIP;
                     end
                  end
                  MD_ADDR: begin
                     addr     <= {blk, rx_byte};
                     ack_go   <= 1'b1;
                     nxt_mode <= MD_WDATA;
                  end
                  MD_WDATA: begin
                     addr[PAGE_W-1:0] <= addr[PAGE_W-1:0] + 1'b1;
                     ack_go           <= 1'b1;
                     nxt_mode         <= MD_WDATA;
                  end
                  default: ;
               endcase
            end
         end else if (scl_fall) begin
            if (bitcnt == 4'd8) begin
               sda_pull <= (mode != MD_RDATA) && ack_go;
            end else if (bitcnt == 4'd9) begin
               bitcnt <= '0;
               if (mode == MD_RDATA) begin
                  if (mack) begin
                     txbyte   <= rd_data;
                     sda_pull <= !rd_data[7];
                     addr     <= addr + 1'b1;
                  end else begin
                     mode     <= MD_SKIP;
                     sda_pull <= 1'b0;
                  end
               end else if (nxt_mode == MD_RDATA) begin
                  mode     <= MD_RDATA;
                  txbyte   <= rd_data;
                  sda_pull <= !rd_data[7];
                  addr     <= addr + 1'b1;
               end else begin
                  mode     <= nxt_mode;
                  sda_pull <= 1'b0;
               end
            end else if (mode == MD_RDATA && bitcnt != 4'd0) begin
               sda_pull <= !txbyte[bidx];
            end
         end
      end
   end

endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave #(
   parameter int ADDR_W      = 11,
   parameter int PAGE_W      = 4,
   parameter int WR_CYCLES   = 250000,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   input  logic wp_i,
   output logic sda_pull_o
);

   if (ADDR_W < 9 || ADDR_W > 11) begin : g_bad_addr_w
      $error("ADDR_W must lie between 9 and 11");
   end
   if (PAGE_W < 1 || PAGE_W > 8 || PAGE_W >= ADDR_W) begin : g_bad_page_w
      $error("PAGE_W must lie between 1 and 8 and stay below ADDR_W");
   end
   if (WR_CYCLES < 1) begin : g_bad_wr_cycles
      $error("WR_CYCLES must be at least 1");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 1");
   end

   logic              scl_s;
   logic              sda_s;
   logic              scl_rise;
   logic              scl_fall;
   logic              start_evt;
   logic              stop_evt;
   logic              wr_busy;
   logic [ADDR_W-1:0] cur_addr;
   logic [7:0]        rd_data;
   logic              buf_we;
   logic [PAGE_W-1:0] buf_off;
   logic [7:0]        buf_din;
   logic              commit;
   logic              buf_clr;

   assign commit  = stop_evt & ~wp_i;
   assign buf_clr = start_evt | (stop_evt & wp_i);

   seeps_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_evt (start_evt),
      .stop_evt  (stop_evt)
   );

   seeps_proto #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_proto (
      .clk       (clk),
      .rst_n     (rst_n),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_evt (start_evt),
      .stop_evt  (stop_evt),
      .busy      (wr_busy),
      .rd_data   (rd_data),
      .addr      (cur_addr),
      .buf_we    (buf_we),
      .buf_off   (buf_off),
      .buf_din   (buf_din),
      .sda_pull  (sda_pull_o)
   );

   seeps_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_array (
      .clk         (clk),
      .rst_n       (rst_n),
      .rd_addr     (cur_addr),
      .rd_data     (rd_data),
      .buf_we      (buf_we),
      .buf_off     (buf_off),
      .buf_din     (buf_din),
      .buf_clr     (buf_clr),
      .commit      (commit),
      .commit_page (cur_addr[ADDR_W-1:PAGE_W]),
      .busy        (wr_busy)
   );

endmodule

// File: rtl/serial_eeprom_slave_chk.sv
module serial_eeprom_slave_chk #(
   parameter int WR_CYCLES = 250000
) (
   input logic clk,
   input logic rst_n,
   input logic wp_i,
   input logic scl_s,
   input logic start_evt,
   input logic stop_evt,
   input logic busy,
   input logic sda_pull
);

   localparam int CW = $clog2(WR_CYCLES + 2);

   logic [CW-1:0] busy_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_cnt <= '0;
      else if (busy) busy_cnt <= busy_cnt + 1'b1;
      else           busy_cnt <= '0;
   end

   assert_release_on_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      stop_evt |=> !sda_pull);

   assert_pull_moves_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_pull != $past(sda_pull) && !$past(start_evt) && !$past(stop_evt)) |-> !$past(scl_s));

   assert_commit_after_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(stop_evt));

   assert_cycle_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (busy_cnt == CW'(WR_CYCLES)));

   assert_quiet_while_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !sda_pull);

   assert_protect_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !$past(wp_i));

endmodule

bind serial_eeprom_slave serial_eeprom_slave_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wp_i      (wp_i),
   .scl_s     (scl_s),
   .start_evt (start_evt),
   .stop_evt  (stop_evt),
   .busy      (wr_busy),
   .sda_pull  (sda_pull_o)
);

// File: tb/serial_eeprom_slave_tb.sv
`timescale 1ns/1ps
module serial_eeprom_slave_tb;

   localparam int Q      = 8;
   localparam int WR_CYC = 1500;
   localparam int NVEC   = 7;
   // each entry: {11-bit address, data byte}
   localparam logic [18:0] VEC [NVEC] = '{
      {11'h000, 8'hA5}, {11'h001, 8'h3C}, {11'h155, 8'h5A}, {11'h2AA, 8'hC3},
      {11'h40C, 8'h81}, {11'h7FE, 8'h7E}, {11'h7FF, 8'hE7}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic sda_m = 1'b1;
   logic wp = 1'b0;
   logic sda_pull;
   logic sda_bus;

   int nchk = 0;
   int nfail = 0;

   logic [7:0]  exp_mem [2048];
   logic [7:0]  wbuf [17];
   logic [7:0]  rbuf [17];
   logic [10:0] exp_addr;

   assign sda_bus = sda_m & ~sda_pull;

   always #10 clk = ~clk;

   serial_eeprom_slave #(.WR_CYCLES(WR_CYC)) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl),
      .sda_i      (sda_bus),
      .wp_i       (wp),
      .sda_pull_o (sda_pull)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic bus_start();
      sda_m = 1'b1; tick(Q);
      scl = 1'b1;   tick(Q);
      sda_m = 1'b0; tick(Q);
      scl = 1'b0;   tick(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; tick(Q);
      scl = 1'b1;   tick(Q);
      sda_m = 1'b1; tick(2 * Q);
   endtask

   task automatic put_bit(input logic b);
      sda_m = b;  tick(Q);
      scl = 1'b1; tick(2 * Q);
      scl = 1'b0; tick(Q);
   endtask

   task automatic get_bit(output logic b);
      sda_m = 1'b1; tick(Q);
      scl = 1'b1;   tick(Q);
      b = sda_bus;  tick(Q);
      scl = 1'b0;   tick(Q);
   endtask

   task automatic put_byte(input logic [7:0] d, output bit ack);
      logic b;
      for (int i = 7; i >= 0; i--) put_bit(d[i]);
      get_bit(b);
      ack = !b;
   endtask

   task automatic get_byte(output logic [7:0] d, input bit mack);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         get_bit(b);
         d[i] = b;
      end
      put_bit(!mack);
   endtask

   function automatic logic [7:0] dev(input logic [2:0] blk, input logic rd);
      return {4'b1010, blk, rd};
   endfunction

   task automatic write_seq(input logic [10:0] a, input int n, output bit ok);
      bit ack;
      ok = 1'b1;
      bus_start();
      put_byte(dev(a[10:8], 1'b0), ack); ok &= ack;
      put_byte(a[7:0], ack);             ok &= ack;
      for (int k = 0; k < n; k++) begin
         put_byte(wbuf[k], ack);
         ok &= ack;
      end
      bus_stop();
   endtask

   task automatic poll(output int nacks);
      bit ack;
      nacks = 0;
      for (int t = 0; t < 60; t++) begin
         bus_start();
         put_byte(dev(3'd0, 1'b0), ack);
         bus_stop();
         if (ack) break;
         nacks++;
      end
   endtask

   task automatic rand_read(input logic [10:0] a, input int n, output bit ok);
      bit ack;
      ok = 1'b1;
      bus_start();
      put_byte(dev(a[10:8], 1'b0), ack); ok &= ack;
      put_byte(a[7:0], ack);             ok &= ack;
      bus_start();
      put_byte(dev(a[10:8], 1'b1), ack); ok &= ack;
      for (int k = 0; k < n; k++) get_byte(rbuf[k], k != n - 1);
      bus_stop();
   endtask

   task automatic model_write(input logic [10:0] a, input int n);
      for (int k = 0; k < n; k++)
         exp_mem[{a[10:4], 4'(a[3:0] + 4'(k))}] = wbuf[k];
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog: run did not complete, actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      bit ok;
      bit ack;
      int nk;
      tick(5);
      rst_n = 1'b1;
      tick(5);
      chk(sda_pull == 1'b0, "R9", "released after reset", int'(sda_pull), 0);

      // vector table: single-byte write, poll, random read back
      for (int v = 0; v < NVEC; v++) begin
         logic [10:0] a;
         a = VEC[v][18:8];
         wbuf[0] = VEC[v][7:0];
         write_seq(a, 1, ok);
         chk(ok, "R1 R2", "byte write acknowledged", int'(ok), 1);
         poll(nk);
         chk(nk >= 2, "R4", "address ignored during write cycle", nk, 2);
         model_write(a, 1);
         rand_read(a, 1, ok);
         chk(ok && rbuf[0] == exp_mem[a], "R2 R6", "random read data",
             int'(rbuf[0]), int'(exp_mem[a]));
      end

      // wrong prefix must not be acknowledged
      bus_start();
      put_byte(8'b1011_0000, ack);
      bus_stop();
      chk(!ack, "R1", "foreign prefix left unacknowledged", int'(ack), 0);

      // full page at 0x230
      for (int k = 0; k < 16; k++) wbuf[k] = 8'h30 + 8'(k);
      write_seq(11'h230, 16, ok);
      chk(ok, "R3", "full page acknowledged", int'(ok), 1);
      poll(nk);
      model_write(11'h230, 16);
      rand_read(11'h230, 16, ok);
      for (int k = 0; k < 16; k++)
         chk(rbuf[k] == exp_mem[11'h230 + 11'(k)], "R3", "page byte",
             int'(rbuf[k]), int'(exp_mem[11'h230 + 11'(k)]));

      // partial page at offset 14 wrapping to offset 0
      wbuf[0] = 8'hE1; wbuf[1] = 8'hE2; wbuf[2] = 8'hE3;
      write_seq(11'h23E, 3, ok);
      poll(nk);
      model_write(11'h23E, 3);
      rand_read(11'h230, 16, ok);
      chk(rbuf[0] == 8'hE3, "R3", "offset wraps to page start", int'(rbuf[0]), 'hE3);
      for (int k = 1; k < 16; k++)
         chk(rbuf[k] == exp_mem[11'h230 + 11'(k)], "R10", "partial page byte",
             int'(rbuf[k]), int'(exp_mem[11'h230 + 11'(k)]));

      // write protect
      wp = 1'b1;
      wbuf[0] = 8'h77;
      write_seq(11'h155, 1, ok);
      poll(nk);
      chk(nk == 0, "R5", "no write cycle under protect", nk, 0);
      wp = 1'b0;
      rand_read(11'h155, 1, ok);
      chk(rbuf[0] == exp_mem[11'h155], "R5", "protected byte kept",
          int'(rbuf[0]), int'(exp_mem[11'h155]));

      // sequential read across the top of memory
      rand_read(11'h7FE, 3, ok);
      chk(rbuf[0] == exp_mem[11'h7FE], "R7", "byte at 0x7FE", int'(rbuf[0]), int'(exp_mem[11'h7FE]));
      chk(rbuf[1] == exp_mem[11'h7FF], "R7", "byte at 0x7FF", int'(rbuf[1]), int'(exp_mem[11'h7FF]));
      chk(rbuf[2] == exp_mem[11'h000], "R7", "rollover to 0x000", int'(rbuf[2]), int'(exp_mem[11'h000]));
      exp_addr = 11'h001;

      // current-address read, block bits in the read device byte ignored
      bus_start();
      put_byte(dev(3'b110, 1'b1), ack);
      get_byte(rbuf[0], 1'b0);
      bus_stop();
      chk(ack && rbuf[0] == exp_mem[exp_addr], "R8", "current address read",
          int'(rbuf[0]), int'(exp_mem[exp_addr]));
      tick(4);
      chk(sda_pull == 1'b0, "R9", "released after stop", int'(sda_pull), 0);

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule